// File: doc/BRIEF.md
# Exception Prioritiser and Mode Entry

This block sits beside a processor core's control unit and arbitrates between the exception requests that can be raised in the same cycle: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. In each cycle it drops any interrupt request that the current status word disables. It then picks the highest-ranked request that is left and computes the complete state change for entering that exception.

The results are the handler vector, the updated status word with the new mode and mask bits, and a copy of the old status word for the saved status register of the target mode. The target mode code tells the banked register file which saved register to write. The return address goes to the link register.

The core samples the requests together with its live status word and return address. One clock later it sees a single-cycle take strobe with all results valid. Between entries the result outputs hold their last values.

Top module: `exc_prio_top`

## Requirements
- R1: While rst_n is low, take_o is 0 and vector_o, new_status_o, saved_status_o, saved_mode_o and link_o are all zero.
- R2: When several requests are eligible in the same cycle, one is served in this order from highest to lowest: reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R3: Each source has a byte vector on vector_o: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R4: The target mode on saved_mode_o, also written into new_status_o[4:0], is 5'b10011 for reset and software interrupt, 5'b10111 for either abort, 5'b11011 for undefined, 5'b10010 for IRQ and 5'b10001 for FIQ.
- R5: new_status_o equals the old status word with bit 7 (I) set and bit 5 (T) cleared. Bit 6 (F) is set for reset and FIQ and kept for all other sources. Bits 31:8, which include the flags in 31:28, are passed through unchanged.
- R6: An IRQ request is ignored while cur_status[7] is 1, and an FIQ request is ignored while cur_status[6] is 1. A cycle whose only requests are masked produces no take_o and leaves all result outputs unchanged.
- R7: Reset, both aborts, undefined and software interrupt are served whatever the I and F bits are.
- R8: Results appear one clock after the requests are sampled, with take_o high for exactly that cycle. After any edge with no eligible request, take_o is 0 and the result outputs keep their previous values.
- R9: saved_status_o is the status word sampled with the served request, and link_o is the ret_pc sampled with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_reset | input | 1 | Reset exception request |
| req_dabort | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabort | input | 1 | Prefetch abort request |
| req_swi | input | 1 | Software interrupt request |
| req_undef | input | 1 | Undefined instruction request |
| cur_status | input | ST_W | Current status word |
| ret_pc | input | PC_W | Return address for the exception |
| take_o | output | 1 | One-cycle strobe: an exception is entered |
| vector_o | output | PC_W | Handler vector address |
| new_status_o | output | ST_W | Status word after entry |
| saved_status_o | output | ST_W | Value for the target mode's saved status register |
| saved_mode_o | output | 5 | Target mode code, selects the saved status register |
| link_o | output | PC_W | Value for the link register |

## Verification
The bench builds the block with its defaults: a 32-bit status word, a 32-bit return address and the registered output variant. With these settings the one-cycle latency of R8 and the hold behaviour between entries can be seen at the ports. Full-width status patterns show whether the flag bits and the unused middle bits pass through, and whether I, F and T change independently. A descending ladder of simultaneous requests, together with mixes of masked and unmasked interrupts, covers every rung of the priority order and both mask bits.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

   localparam int NUM_SRC = 7;
   localparam int MODE_W  = 5;
   localparam int VOFF_W  = 5;

   // Source index equals priority rank: 0 is served first.
   localparam int IDX_RESET = 0;
   localparam int IDX_DABT  = 1;
   localparam int IDX_FIQ   = 2;
   localparam int IDX_IRQ   = 3;
   localparam int IDX_PABT  = 4;
   localparam int IDX_UNDEF = 5;
   localparam int IDX_SWI   = 6;

   localparam int BIT_I = 7;
   localparam int BIT_F = 6;
   localparam int BIT_T = 5;

   localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
   localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
   localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
   localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
   localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
   localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
   localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

   function automatic logic [MODE_W-1:0] src_mode(input int idx);
      case (idx)
         IDX_RESET: return MODE_SVC;
         IDX_DABT:  return MODE_ABT;
         IDX_FIQ:   return MODE_FIQ;
         IDX_IRQ:   return MODE_IRQ;
         IDX_PABT:  return MODE_ABT;
         IDX_UNDEF: return MODE_UND;
         IDX_SWI:   return MODE_SVC;
         default:   return MODE_USR;
      endcase
   endfunction

   function automatic logic [VOFF_W-1:0] src_vector(input int idx);
      case (idx)
         IDX_RESET: return 5'h00;
         IDX_UNDEF: return 5'h04;
         IDX_SWI:   return 5'h08;
         IDX_PABT:  return 5'h0C;
         IDX_DABT:  return 5'h10;
         IDX_IRQ:   return 5'h18;
         IDX_FIQ:   return 5'h1C;
         default:   return 5'h00;
      endcase
   endfunction

   function automatic logic src_sets_f(input int idx);
      return (idx == IDX_RESET) || (idx == IDX_FIQ);
   endfunction

endpackage

// File: rtl/exc_prio_mask.sv
module exc_prio_mask
   import exc_prio_pkg::*;
(
   input  logic [NUM_SRC-1:0] req_raw,
   input  logic               irq_off,
   input  logic               fiq_off,
   output logic [NUM_SRC-1:0] req_ok
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      if (g == IDX_IRQ) begin : g_irq
         assign req_ok[g] = req_raw[g] & ~irq_off;
      end else if (g == IDX_FIQ) begin : g_fiq
         assign req_ok[g] = req_raw[g] & ~fiq_off;
      end else begin : g_pass
         assign req_ok[g] = req_raw[g];
      end
   end
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
   import exc_prio_pkg::*;
(
   input  logic [NUM_SRC-1:0] req_ok,
   output logic [NUM_SRC-1:0] grant,
   output logic               any
);
   always_comb begin
      logic seen;
      seen  = 1'b0;
      grant = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         grant[i] = req_ok[i] & ~seen;
         seen     = seen | req_ok[i];
      end
      any = seen;
   end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
   import exc_prio_pkg::*;
#(
   parameter int PC_W = 32,
   parameter int ST_W = 32
)(
   input  logic [NUM_SRC-1:0] grant,
   input  logic [ST_W-1:0]    status_in,
   output logic [PC_W-1:0]    vector,
   output logic [MODE_W-1:0]  mode,
   output logic [ST_W-1:0]    status_out
);
   logic [VOFF_W-1:0] voff;
   logic              set_f;

   always_comb begin
      voff  = '0;
      mode  = '0;
      set_f = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (grant[i]) begin
            voff  = voff | src_vector(i);
            mode  = mode | src_mode(i);
            set_f = set_f | src_sets_f(i);
         end
      end
   end

   assign vector = PC_W'(voff);

   always_comb begin
      status_out               = status_in;
      status_out[MODE_W-1:0]   = mode;
      status_out[BIT_I]        = 1'b1;
      status_out[BIT_T]        = 1'b0;
      if (set_f) status_out[BIT_F] = 1'b1;
   end
endmodule

// File: rtl/exc_prio_top.sv
module exc_prio_top
   import exc_prio_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int ST_W    = 32,
   parameter int REG_OUT = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_reset,
   input  logic              req_dabort,
   input  logic              req_fiq,
   input  logic              req_irq,
   input  logic              req_pabort,
   input  logic              req_swi,
   input  logic              req_undef,
   input  logic [ST_W-1:0]   cur_status,
   input  logic [PC_W-1:0]   ret_pc,
   output logic              take_o,
   output logic [PC_W-1:0]   vector_o,
   output logic [ST_W-1:0]   new_status_o,
   output logic [ST_W-1:0]   saved_status_o,
   output logic [4:0]        saved_mode_o,
   output logic [PC_W-1:0]   link_o
);
   if (PC_W <= VOFF_W) begin : g_bad_pc
      $error("exc_prio_top: PC_W must exceed the vector offset width");
   end
   if (ST_W < 8) begin : g_bad_st
      $error("exc_prio_top: ST_W must cover the mode and mask bits");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("exc_prio_top: REG_OUT must be 0 or 1");
   end

   logic [NUM_SRC-1:0] req_raw, req_ok, grant;
   logic               any;
   logic [PC_W-1:0]    vec_c;
   logic [MODE_W-1:0]  mode_c;
   logic [ST_W-1:0]    status_c;

   always_comb begin
      req_raw            = '0;
      req_raw[IDX_RESET] = req_reset;
      req_raw[IDX_DABT]  = req_dabort;
      req_raw[IDX_FIQ]   = req_fiq;
      req_raw[IDX_IRQ]   = req_irq;
      req_raw[IDX_PABT]  = req_pabort;
      req_raw[IDX_UNDEF] = req_undef;
      req_raw[IDX_SWI]   = req_swi;
   end

   exc_prio_mask u_mask (
      .req_raw (req_raw),
      .irq_off (cur_status[BIT_I]),
      .fiq_off (cur_status[BIT_F]),
      .req_ok  (req_ok)
   );

   exc_prio_arb u_arb (
      .req_ok (req_ok),
      .grant  (grant),
      .any    (any)
   );

   exc_entry_calc #(.PC_W(PC_W), .ST_W(ST_W)) u_calc (
      .grant      (grant),
      .status_in  (cur_status),
      .vector     (vec_c),
      .mode       (mode_c),
      .status_out (status_c)
   );

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            take_o         <= 1'b0;
            vector_o       <= '0;
            new_status_o   <= '0;
            saved_status_o <= '0;
            saved_mode_o   <= '0;
            link_o         <= '0;
         end else begin
            take_o <= any;
            if (any) begin
               vector_o       <= vec_c;
               new_status_o   <= status_c;
               saved_status_o <= cur_status;
               saved_mode_o   <= mode_c;
               link_o         <= ret_pc;
            end
         end
      end
   end else begin : g_comb
      assign take_o         = any;
      assign vector_o       = vec_c;
      assign new_status_o   = status_c;
      assign saved_status_o = cur_status;
      assign saved_mode_o   = mode_c;
      assign link_o         = ret_pc;
   end
endmodule

// File: rtl/exc_prio_chk.sv
module exc_prio_chk #(
   parameter int PC_W    = 32,
   parameter int ST_W    = 32,
   parameter int REG_OUT = 1
)(
   input logic            clk,
   input logic            rst_n,
   input logic            req_reset,
   input logic            req_dabort,
   input logic            req_fiq,
   input logic            req_irq,
   input logic            req_pabort,
   input logic            req_swi,
   input logic            req_undef,
   input logic [ST_W-1:0] cur_status,
   input logic [PC_W-1:0] ret_pc,
   input logic            take_o,
   input logic [PC_W-1:0] vector_o,
   input logic [ST_W-1:0] new_status_o,
   input logic [ST_W-1:0] saved_status_o,
   input logic [4:0]      saved_mode_o,
   input logic [PC_W-1:0] link_o
);
   if (REG_OUT == 1) begin : g_seq
      a_r2_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
         req_reset |=> take_o && vector_o == '0 && saved_mode_o == 5'b10011);

      a_r7_dabt_served: assert property (@(posedge clk) disable iff (!rst_n)
         (req_dabort && !req_reset) |=>
            take_o && vector_o == PC_W'(16) && saved_mode_o == 5'b10111);

      a_r3_fiq_entry: assert property (@(posedge clk) disable iff (!rst_n)
         (req_fiq && !cur_status[6] && !req_reset && !req_dabort) |=>
            take_o && vector_o == PC_W'(28) && saved_mode_o == 5'b10001
            && new_status_o[6]);

      a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
         (req_irq && cur_status[7] && !req_reset && !req_dabort && !req_fiq
          && !req_pabort && !req_swi && !req_undef) |=> !take_o);

      a_r5_mask_bits: assert property (@(posedge clk) disable iff (!rst_n)
         take_o |-> new_status_o[7] && !new_status_o[5]);

      a_r9_saved_copy: assert property (@(posedge clk) disable iff (!rst_n)
         (req_reset || req_dabort || req_pabort || req_swi || req_undef) |=>
            saved_status_o == $past(cur_status) && link_o == $past(ret_pc));

      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !take_o |-> $stable(vector_o) && $stable(new_status_o)
                     && $stable(saved_status_o) && $stable(link_o));
   end
endmodule

bind exc_prio_top exc_prio_chk #(.PC_W(PC_W), .ST_W(ST_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_exc_prio_top.sv
`timescale 1ns/1ps
module tb_exc_prio_top;
   localparam int PC_W = 32;
   localparam int ST_W = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n;
   logic r_reset, r_dabt, r_fiq, r_irq, r_pabt, r_undef, r_swi;
   logic [ST_W-1:0] cur_status;
   logic [PC_W-1:0] ret_pc;
   logic            take_o;
   logic [PC_W-1:0] vector_o, link_o;
   logic [ST_W-1:0] new_status_o, saved_status_o;
   logic [4:0]      saved_mode_o;

   exc_prio_top #(.PC_W(PC_W), .ST_W(ST_W), .REG_OUT(1)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_reset(r_reset), .req_dabort(r_dabt), .req_fiq(r_fiq),
      .req_irq(r_irq), .req_pabort(r_pabt), .req_swi(r_swi),
      .req_undef(r_undef),
      .cur_status(cur_status), .ret_pc(ret_pc),
      .take_o(take_o), .vector_o(vector_o), .new_status_o(new_status_o),
      .saved_status_o(saved_status_o), .saved_mode_o(saved_mode_o),
      .link_o(link_o)
   );

   int n_checks = 0;
   int n_errors = 0;
   logic [31:0] e_vec, e_ns, e_ss, e_link;
   logic [4:0]  e_mode;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   // r = {reset, dabt, fiq, irq, pabt, undef, swi}
   task automatic drive(input logic [6:0] r, input logic [31:0] st, input logic [31:0] pc);
      {r_reset, r_dabt, r_fiq, r_irq, r_pabt, r_undef, r_swi} = r;
      cur_status = st;
      ret_pc     = pc;
   endtask

   task automatic run_case(input string req, input logic [6:0] r,
                           input logic [31:0] st, input logic [31:0] pc);
      logic t, sf;
      logic [31:0] v, ns;
      logic [4:0] m;
      t = 1'b1; sf = 1'b0; v = '0; m = '0;
      if (r[6])                 begin v = 32'h00; m = 5'b10011; sf = 1'b1; end
      else if (r[5])            begin v = 32'h10; m = 5'b10111; end
      else if (r[4] && !st[6])  begin v = 32'h1C; m = 5'b10001; sf = 1'b1; end
      else if (r[3] && !st[7])  begin v = 32'h18; m = 5'b10010; end
      else if (r[2])            begin v = 32'h0C; m = 5'b10111; end
      else if (r[1])            begin v = 32'h04; m = 5'b11011; end
      else if (r[0])            begin v = 32'h08; m = 5'b10011; end
      else t = 1'b0;
      @(negedge clk);
      drive(r, st, pc);
      @(posedge clk);
      @(negedge clk);
      if (t) begin
         ns = st;
         ns[4:0] = m;
         ns[7] = 1'b1;
         ns[5] = 1'b0;
         if (sf) ns[6] = 1'b1;
         e_vec = v; e_ns = ns; e_ss = st; e_link = pc; e_mode = m;
      end
      chk(req, "take", {31'd0, take_o}, {31'd0, t});
      chk(req, "vector", vector_o, e_vec);
      chk(req, "new_status", new_status_o, e_ns);
      chk(req, "saved_status", saved_status_o, e_ss);
      chk(req, "link", link_o, e_link);
      chk(req, "mode", {27'd0, saved_mode_o}, {27'd0, e_mode});
      drive(7'b0, st, pc);
   endtask

   task automatic t_reset_state();
      chk("R1", "take", {31'd0, take_o}, 32'd0);
      chk("R1", "vector", vector_o, 32'd0);
      chk("R1", "new_status", new_status_o, 32'd0);
      chk("R1", "saved_status", saved_status_o, 32'd0);
      chk("R1", "link", link_o, 32'd0);
      chk("R1", "mode", {27'd0, saved_mode_o}, 32'd0);
   endtask

   // R3 R4 R5 R9: each source alone, flags and T set, I and F clear
   task automatic t_singles();
      run_case("R3_R4_reset", 7'b1000000, 32'hA000_0030, 32'h0000_1000);
      run_case("R3_R4_dabt",  7'b0100000, 32'h5000_0030, 32'h0000_2004);
      run_case("R3_R4_fiq",   7'b0010000, 32'hA000_0030, 32'h0000_3008);
      run_case("R3_R4_irq",   7'b0001000, 32'hF0F0_0030, 32'h0000_400C);
      run_case("R3_R4_pabt",  7'b0000100, 32'h3000_0030, 32'h0000_5010);
      run_case("R3_R4_undef", 7'b0000010, 32'h9000_0030, 32'h0000_6014);
      run_case("R3_R4_swi",   7'b0000001, 32'h6000_0030, 32'h0000_7018);
   endtask

   // R2: descending ladder of simultaneous requests
   task automatic t_priority();
      run_case("R2_all",       7'b1111111, 32'h0000_0010, 32'h0001_0000);
      run_case("R2_no_reset",  7'b0111111, 32'h0000_0010, 32'h0001_0004);
      run_case("R2_from_fiq",  7'b0011111, 32'h0000_0010, 32'h0001_0008);
      run_case("R2_from_irq",  7'b0001111, 32'h0000_0010, 32'h0001_000C);
      run_case("R2_from_pabt", 7'b0000111, 32'h0000_0010, 32'h0001_0010);
      run_case("R2_undef_swi", 7'b0000011, 32'h0000_0010, 32'h0001_0014);
   endtask

   // R6 R7 R5: masking and F-bit retention
   task automatic t_masking();
      run_case("R6_irq_masked",   7'b0001000, 32'h8000_0090, 32'h0002_0000);
      run_case("R6_fiq_masked",   7'b0010000, 32'h4000_0050, 32'h0002_0004);
      run_case("R6_fiq_to_irq",   7'b0011000, 32'h0000_0050, 32'h0002_0008);
      run_case("R7_pabt_both_off",7'b0011100, 32'h0000_00D0, 32'h0002_000C);
      run_case("R7_swi_both_off", 7'b0000001, 32'h0000_00D3, 32'h0002_0010);
      run_case("R5_irq_f_clear",  7'b0001000, 32'h0000_001F, 32'h0002_0014);
   endtask

   // R8: latency, one-cycle strobe, hold afterwards
   task automatic t_latency();
      @(negedge clk);
      drive(7'b0100000, 32'h0000_0010, 32'h0003_0000);
      #1;
      chk("R8", "take before edge", {31'd0, take_o}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      chk("R8", "take after edge", {31'd0, take_o}, 32'd1);
      chk("R8", "vector after edge", vector_o, 32'h10);
      drive(7'b0, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
      @(posedge clk);
      @(negedge clk);
      chk("R8", "strobe drops", {31'd0, take_o}, 32'd0);
      chk("R8", "vector held", vector_o, 32'h10);
      chk("R8", "saved held", saved_status_o, 32'h0000_0010);
      chk("R8", "link held", link_o, 32'h0003_0000);
      e_vec = 32'h10; e_ss = 32'h0000_0010; e_link = 32'h0003_0000;
      e_ns = 32'h0000_0097; e_mode = 5'b10111;
      chk("R8", "new_status held", new_status_o, e_ns);
   endtask

   // R1: reset in the middle of operation clears the outputs
   task automatic t_mid_reset();
      run_case("R9_before_reset", 7'b0000010, 32'h1234_5610, 32'h0004_0000);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      t_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      e_vec = '0; e_ns = '0; e_ss = '0; e_link = '0; e_mode = '0;
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      e_vec = '0; e_ns = '0; e_ss = '0; e_link = '0; e_mode = '0;
      rst_n = 1'b0;
      drive(7'b1111111, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset_state();
      drive(7'b0, 32'h0000_0010, 32'h0);
      rst_n = 1'b1;
      t_singles();
      t_priority();
      t_masking();
      t_latency();
      t_mid_reset();
      run_case("R3_after_reset", 7'b0000100, 32'h0000_0010, 32'h0005_0000);
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule